// File: doc/BRIEF.md
# Tiled Surface Address Swizzler

This block turns a pixel location on a graphics surface into the byte address of that pixel relative to the start of the surface. The location is given as a byte column and a row. The surface is described by its pitch in bytes and by one of three memory layouts:

- **Linear:** rows are laid out one after another.
- **Wide tile:** 4 KB tiles made of 8 rows of 512 bytes.
- **Column tile:** 4 KB tiles made of 16-byte columns, each 32 rows deep.

For the two tiled layouts, an optional scramble can be applied to address bit 6. It XORs bit 6 with one or more of bits 9, 10 and 11 of the offset inside the tile. This matches the way a memory controller spreads accesses across channels.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, one cycle after acceptance. The input is accepted in any cycle where the output register is empty or is being drained, so `in_ready = !out_valid || out_ready`. While `out_ready` is low, a pending result holds steady and no new request is taken. A source that drops `in_valid` before acceptance simply withdraws its request.

An unknown scramble code or the reserved layout code does not produce an address. It produces a result flagged as an error, with the address forced to zero.

Top module: `tile_swizzler`

## Requirements
- R1: A synchronous reset makes `out_valid` and `out_err` low on the clock edge that samples it.
- R2: A request is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is shown on the next cycle with `out_valid` high. `out_valid` goes low after a cycle where the result was taken (`out_ready` high) and no new request came in.
- R3: While `out_valid` is high and `out_ready` is low, `out_addr` and `out_err` keep their values, and `in_ready` is low.
- R4: Layout code 0 (linear) gives `y * pitch + x`, and no bit-6 scramble is applied.
- R5: Layout code 1 (wide tile) uses an in-tile offset of `(y mod 8) * 512 + (x mod 512)`. The tile column is `x / 512` and the tile row is `y / 8`. Tile rows are `pitch * 8` bytes apart.
- R6: Layout code 2 (column tile) uses an in-tile offset of `((x mod 128) / 16) * 512 + (y mod 32) * 16 + (x mod 16)`. The tile column is `x / 128` and the tile row is `y / 32`. Tile rows are `pitch * 32` bytes apart.
- R7: For both tiled layouts the address is `tile_column * 4096 + tile_row * tile_row_stride + scrambled_offset`. All arithmetic wraps modulo 2^32.
- R8: Scramble codes are applied to the in-tile offset before the tile base is added. In each case the offset's bit 6 is XORed with the listed bits:

  | Code | Bit 6 XORed with |
  |------|------------------|
  | 0 | nothing |
  | 1 | bit 9 |
  | 2 | bits 9 and 10 |
  | 3 | bits 9 and 11 |
  | 4 | bits 9, 10 and 11 |

- R9: Scramble codes 5 to 7, or layout code 3, give a result with `out_err` high and `out_addr` zero. This holds for any layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request will be taken this cycle |
| in_x | input | 16 | Byte column within the surface |
| in_y | input | 16 | Row within the surface |
| in_pitch | input | 16 | Surface pitch in bytes |
| in_tiling | input | 2 | Layout: 0 linear, 1 wide tile, 2 column tile, 3 reserved |
| in_swz | input | 3 | Bit-6 scramble code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Byte address relative to the surface start |
| out_err | output | 1 | Request carried an unknown code |

## Verification
The only state is the one-entry output register and its occupancy bit. A wrong occupancy bit shows up in the same cycle as a duplicated, lost or phantom result, and `in_ready` disagrees with the consumer's view one cycle after the bad transfer. A wrong address or a wrong scramble term is purely combinational, so it appears on `out_addr` in the cycle right after the request is taken. Running every layout against every scramble code, on coordinates that set bits 9 to 11 in different combinations, exposes each term on its own.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int OFS_W = 12;  // every tile is 2^12 bytes

  localparam logic [1:0] TIL_LIN  = 2'd0;
  localparam logic [1:0] TIL_WIDE = 2'd1;
  localparam logic [1:0] TIL_COL  = 2'd2;

  localparam logic [2:0] SWZ_NONE   = 3'd0;
  localparam logic [2:0] SWZ_B9     = 3'd1;
  localparam logic [2:0] SWZ_B9_10  = 3'd2;
  localparam logic [2:0] SWZ_B9_11  = 3'd3;
  localparam logic [2:0] SWZ_B9_ALL = 3'd4;

  localparam int GEO_N = 2;  // index 0 wide tile, index 1 column tile

  function automatic int geo_span_log2(input int g);
    return (g == 0) ? 9 : 7;
  endfunction

  function automatic int geo_rows_log2(input int g);
    return (g == 0) ? 3 : 5;
  endfunction

  function automatic int geo_col_log2(input int g);
    return (g == 0) ? 9 : 4;
  endfunction
endpackage

// File: rtl/tsw_tile_map.sv
module tsw_tile_map
  import tsw_pkg::*;
#(
  parameter int X_W       = 16,
  parameter int Y_W       = 16,
  parameter int P_W       = 16,
  parameter int A_W       = 32,
  parameter int SPAN_LOG2 = 9,
  parameter int ROWS_LOG2 = 3,
  parameter int COL_LOG2  = 9
) (
  input  logic [X_W-1:0]   x,
  input  logic [Y_W-1:0]   y,
  input  logic [P_W-1:0]   pitch,
  output logic [OFS_W-1:0] ofs,
  output logic [A_W-1:0]   base
);
  logic [SPAN_LOG2-1:0] x_in;
  logic [ROWS_LOG2-1:0] row;
  logic [A_W-1:0]       h_idx;
  logic [A_W-1:0]       v_idx;
  logic [A_W-1:0]       row_stride;

  assign x_in       = x[SPAN_LOG2-1:0];
  assign row        = y[ROWS_LOG2-1:0];
  assign h_idx      = A_W'(x[X_W-1:SPAN_LOG2]);
  assign v_idx      = A_W'(y[Y_W-1:ROWS_LOG2]);
  assign row_stride = A_W'(pitch) << ROWS_LOG2;
  assign base       = (h_idx << OFS_W) + v_idx * row_stride;

  generate
    if (COL_LOG2 >= SPAN_LOG2) begin : g_rows
      // one column spans the full tile width: plain row-major tile
      assign ofs = OFS_W'({row, x_in});
    end else begin : g_cols
      // narrow columns stacked full-height, then walked left to right
      assign ofs = OFS_W'({x_in[SPAN_LOG2-1:COL_LOG2], row, x_in[COL_LOG2-1:0]});
    end
  endgenerate
endmodule

// File: rtl/tsw_bit6.sv
module tsw_bit6
  import tsw_pkg::*;
(
  input  logic [OFS_W-1:0] ofs_in,
  input  logic [2:0]       mode,
  output logic [OFS_W-1:0] ofs_out,
  output logic             bad_mode
);
  logic flip;

  always_comb begin
    flip     = 1'b0;
    bad_mode = 1'b0;
    case (mode)
      SWZ_NONE:   flip = 1'b0;
      SWZ_B9:     flip = ofs_in[9];
      SWZ_B9_10:  flip = ofs_in[9] ^ ofs_in[10];
      SWZ_B9_11:  flip = ofs_in[9] ^ ofs_in[11];
      SWZ_B9_ALL: flip = ofs_in[9] ^ ofs_in[10] ^ ofs_in[11];
      default:    bad_mode = 1'b1;
    endcase
  end

  assign ofs_out = {ofs_in[OFS_W-1:7], ofs_in[6] ^ flip, ofs_in[5:0]};
endmodule

// File: rtl/tsw_stage.sv
module tsw_stage #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (s_ready) begin
      vld_q <= s_valid;
      if (s_valid) dat_q <= s_data;
    end
  end
endmodule

// File: rtl/tile_swizzler.sv
module tile_swizzler
  import tsw_pkg::*;
#(
  parameter int X_W = 16,
  parameter int Y_W = 16,
  parameter int P_W = 16,
  parameter int A_W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [X_W-1:0] in_x,
  input  logic [Y_W-1:0] in_y,
  input  logic [P_W-1:0] in_pitch,
  input  logic [1:0]     in_tiling,
  input  logic [2:0]     in_swz,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [A_W-1:0] out_addr,
  output logic           out_err
);
  localparam int PAY_W = A_W + 1;

  logic [OFS_W-1:0] geo_ofs  [GEO_N];
  logic [A_W-1:0]   geo_base [GEO_N];

  generate
    for (genvar g = 0; g < GEO_N; g++) begin : g_geo
      tsw_tile_map #(
        .X_W      (X_W),
        .Y_W      (Y_W),
        .P_W      (P_W),
        .A_W      (A_W),
        .SPAN_LOG2(geo_span_log2(g)),
        .ROWS_LOG2(geo_rows_log2(g)),
        .COL_LOG2 (geo_col_log2(g))
      ) u_map (
        .x    (in_x),
        .y    (in_y),
        .pitch(in_pitch),
        .ofs  (geo_ofs[g]),
        .base (geo_base[g])
      );
    end
  endgenerate

  logic [OFS_W-1:0] sel_ofs;
  logic [A_W-1:0]   sel_base;
  logic [OFS_W-1:0] swz_ofs;
  logic             bad_mode;
  logic             bad;
  logic [A_W-1:0]   lin_addr;
  logic [A_W-1:0]   tile_addr;
  logic [A_W-1:0]   addr;

  always_comb begin
    sel_ofs  = (in_tiling == TIL_COL) ? geo_ofs[1]  : geo_ofs[0];
    sel_base = (in_tiling == TIL_COL) ? geo_base[1] : geo_base[0];
  end

  tsw_bit6 u_bit6 (
    .ofs_in  (sel_ofs),
    .mode    (in_swz),
    .ofs_out (swz_ofs),
    .bad_mode(bad_mode)
  );

  assign lin_addr  = A_W'(in_y) * A_W'(in_pitch) + A_W'(in_x);
  assign tile_addr = sel_base + A_W'(swz_ofs);
  assign bad       = bad_mode || (in_tiling == 2'd3);

  always_comb begin
    if (bad)                    addr = '0;
    else if (in_tiling == TIL_LIN) addr = lin_addr;
    else                        addr = tile_addr;
  end

  logic [PAY_W-1:0] pay_out;

  tsw_stage #(.W(PAY_W)) u_stage (
    .clk    (clk),
    .rst    (rst),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data ({bad, addr}),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (pay_out)
  );

  assign out_err  = pay_out[A_W];
  assign out_addr = pay_out[A_W-1:0];
endmodule

// File: rtl/tile_swizzler_chk.sv
module tile_swizzler_chk #(
  parameter int A_W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2:0]     in_swz,
  input logic           out_valid,
  input logic           out_ready,
  input logic [A_W-1:0] out_addr,
  input logic           out_err
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err)); // R1

  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R2

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err))); // R3

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_swz > 3'd4) |=> out_err); // R9

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_addr == '0)); // R9
endmodule

bind tile_swizzler tile_swizzler_chk #(.A_W(A_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_swz   (in_swz),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_addr (out_addr),
  .out_err  (out_err)
);

// File: tb/test_tile_swizzler.sv
module test_tile_swizzler;
  localparam int CLK_PER = 10;
  localparam int X_W = 16;
  localparam int Y_W = 16;
  localparam int P_W = 16;
  localparam int A_W = 32;

  logic           clk = 1'b0;
  logic           rst;
  logic           in_valid;
  logic           in_ready;
  logic [X_W-1:0] in_x;
  logic [Y_W-1:0] in_y;
  logic [P_W-1:0] in_pitch;
  logic [1:0]     in_tiling;
  logic [2:0]     in_swz;
  logic           out_valid;
  logic           out_ready;
  logic [A_W-1:0] out_addr;
  logic           out_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  tile_swizzler #(.X_W(X_W), .Y_W(Y_W), .P_W(P_W), .A_W(A_W)) i_tile_swizzler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_pitch(in_pitch), .in_tiling(in_tiling),
    .in_swz(in_swz), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_err(out_err)
  );

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference: integer division and remainder per layout
  function automatic void ref_calc(input longint x, input longint y, input longint p,
                                   input int t, input int m, output logic e,
                                   output logic [A_W-1:0] a, output string tag);
    longint ht, vt, r, xi, off, base, res;
    longint f;
    e = 1'b0;
    if (m > 4 || t == 3) begin
      e = 1'b1; a = '0; tag = "R9";
      return;
    end
    if (t == 0) begin
      res = y * p + x;
      tag = "R4";
    end else begin
      if (t == 1) begin
        ht = x / 512; xi = x % 512; vt = y / 8; r = y % 8;
        off = r * 512 + xi;
        base = ht * 4096 + vt * p * 8;
        tag = "R5 R7 R8";
      end else begin
        ht = x / 128; xi = x % 128; vt = y / 32; r = y % 32;
        off = (xi / 16) * 512 + r * 16 + xi % 16;
        base = ht * 4096 + vt * p * 32;
        tag = "R6 R7 R8";
      end
      f = 0;
      if (m >= 1) f = f ^ ((off >> 9) & 1);
      if (m == 2 || m == 4) f = f ^ ((off >> 10) & 1);
      if (m == 3 || m == 4) f = f ^ ((off >> 11) & 1);
      if (f != 0) off = off ^ 64;
      res = base + off;
    end
    a = res[A_W-1:0];
  endfunction

  logic           exp_v;
  logic           exp_e;
  logic [A_W-1:0] exp_a;
  string          exp_tag;
  logic           was_stall;
  logic           n_e;
  logic [A_W-1:0] n_a;
  string          n_tag;

  always @(posedge clk) begin
    if (rst) begin
      exp_v <= 1'b0; exp_e <= 1'b0; was_stall <= 1'b0;
    end else begin
      was_stall <= exp_v && !out_ready;
      if (in_valid && (!exp_v || out_ready)) begin
        ref_calc(longint'(in_x), longint'(in_y), longint'(in_pitch),
                 int'(in_tiling), int'(in_swz), n_e, n_a, n_tag);
        exp_v <= 1'b1; exp_e <= n_e; exp_a <= n_a; exp_tag <= n_tag;
      end else if (out_ready) begin
        exp_v <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (!finished) begin
      if (rst) begin
        chk(!out_valid && !out_err, "R1 reset clears valid/error",
            longint'({out_valid, out_err}), 0);
      end else begin
        chk(out_valid == exp_v, "R2 out_valid", longint'(out_valid), longint'(exp_v));
        chk(in_ready == (!exp_v || out_ready), "R2 R3 in_ready",
            longint'(in_ready), longint'(!exp_v || out_ready));
        if (exp_v) begin
          chk(out_err == exp_e, {exp_tag, was_stall ? " R3" : "", " error flag"},
              longint'(out_err), longint'(exp_e));
          chk(out_addr == exp_a, {exp_tag, was_stall ? " R3" : "", " address"},
              longint'(out_addr), longint'(exp_a));
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [X_W-1:0] x, input logic [Y_W-1:0] y,
                       input logic [P_W-1:0] p, input logic [1:0] t, input logic [2:0] m,
                       input logic rdy);
    @(negedge clk);
    in_valid = v; in_x = x; in_y = y; in_pitch = p;
    in_tiling = t; in_swz = m; out_ready = rdy;
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_x = '0; in_y = '0; in_pitch = '0;
    in_tiling = '0; in_swz = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4 R5 R6 R8 R9: every layout against every scramble code
    for (int t = 0; t < 4; t++) begin
      for (int m = 0; m < 8; m++) begin
        drive(1'b1, 16'h0E70, 16'h00D7, 16'h2000, 2'(t), 3'(m), 1'b1);
        drive(1'b1, 16'h01FF, 16'h0007, 16'h0800, 2'(t), 3'(m), 1'b1);
        drive(1'b1, 16'h0A5C, 16'h003F, 16'h0400, 2'(t), 3'(m), 1'b1);
        drive(1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 2'(t), 3'(m), 1'b1);
      end
    end
    // R3: back-pressure with changing input
    drive(1'b1, 16'h0123, 16'h0045, 16'h1000, 2'd1, 3'd4, 1'b0);
    drive(1'b1, 16'h0200, 16'h0011, 16'h1000, 2'd2, 3'd3, 1'b0);
    drive(1'b1, 16'h0300, 16'h0022, 16'h1000, 2'd0, 3'd0, 1'b0);
    drive(1'b0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 3'd0, 1'b0);
    drive(1'b0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 3'd0, 1'b1);
    drive(1'b0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 3'd0, 1'b1);
    // mixed traffic with random back-pressure
    for (int i = 0; i < 4000; i++) begin
      drive(1'($urandom % 4 != 0), 16'($urandom), 16'($urandom), 16'($urandom),
            2'($urandom), 3'($urandom % 6), 1'($urandom % 3 != 0));
    end
    drive(1'b0, '0, '0, '0, 2'd0, 3'd0, 1'b1);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule